// File: doc/BRIEF.md
# Parallel Word Bus Transfer Engine

This block copies a block of 16-bit words between an on-chip word memory port and an external 16-bit parallel bus. Two devices share that bus: a static RAM whose address is held in an external counter, and a display controller. The engine never drives an address onto the bus. It advances the external counter by pulsing a dedicated counter clock once per word. One sequencer runs all three transfer kinds: bus to memory, memory to RAM, and memory to display.

A job starts with a one-cycle `start` pulse. The pulse carries a command code, a byte base address for the internal memory, a word count and a phase length. The phase length sets the duration of every strobe phase, so the bus can be slowed to suit devices limited to below 20 MHz. The engine pulses `done` when the job ends. It then returns to idle with its data drivers released.

Top module: `pbus_xfer_engine`

## Requirements
- R1: After reset the engine is idle: `busy` and `done` are 0, `bus_oe` is 0, and `ram_rd_n`, `ram_wr_n`, `cnt_clk`, `disp_cs_n` and `disp_wr_n` are all 1.
- R2: Command code 2'b10 (memory to RAM) handles each word in this order: read the word from memory, present it on `bus_dout`, drive `ram_wr_n` low and then high, then drive `cnt_clk` low and then high. The bus holds the word for the whole write strobe.
- R3: Command code 2'b01 (bus to memory) holds `ram_rd_n` low for the whole job. For each word it writes `bus_din` to memory and then pulses `cnt_clk` low and then high. `ram_rd_n` is 1 again once the job ends.
- R4: Command code 2'b11 (memory to display) presents each word and then drives `disp_cs_n` and `disp_wr_n` low together and high together. It issues no `cnt_clk` pulse, and `disp_cs_n` is high when the job ends.
- R5: The first memory access uses `base_addr`. The memory address then rises by 2 for each word moved.
- R6: Every strobe low phase and high phase lasts max(`phase_cycles`,1) clock cycles. This covers the RAM write strobe, the display strobe and the counter clock.
- R7: A word count of 0 ends the job with no strobe and no memory access. `done` appears one cycle after `start`.
- R8: `bus_oe` is 1 only while a memory-to-RAM or memory-to-display job is running. It is never 1 while `ram_rd_n` is low, nor while the engine is idle.
- R9: `done` is a single-cycle pulse after which `busy` is 0. Let Q = max(`phase_cycles`,1) and N = the word count. The number of cycles from the `start` cycle to the `done` cycle is N(2+4Q)+1 for memory to RAM, Q+N(1+2Q)+1 for bus to memory, and N(2+2Q)+1 for memory to display.
- R10: A `start` pulse while `busy` is 1 is ignored. The running job finishes unchanged and no second job follows.
- R11: Command code 2'b00 is a no-operation. It completes like a zero-length job, with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job request, taken only when idle |
| cmd | input | 2 | Command code: 00 none, 01 bus to memory, 10 memory to RAM, 11 memory to display |
| base_addr | input | AW | Byte address of the first memory word |
| word_count | input | CW | Number of words to move |
| phase_cycles | input | PW | Cycles per strobe phase, 0 treated as 1 |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_addr | output | AW | Memory byte address |
| mem_rd_en | output | 1 | Memory read request, data expected one cycle later |
| mem_rd_data | input | DW | Memory read data |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_data | output | DW | Memory write data |
| bus_din | input | DW | Data sampled from the external bus |
| bus_dout | output | DW | Data driven onto the external bus |
| bus_oe | output | 1 | Enable for the external data drivers |
| ram_rd_n | output | 1 | RAM read enable, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| cnt_clk | output | 1 | External address counter clock, idles high |
| disp_cs_n | output | 1 | Display chip select, active low |
| disp_wr_n | output | 1 | Display write strobe, active low |

## Verification
The bound assertions check, on every cycle, the rules that hold locally in time. At most one strobe is low at any time. The drivers stay off while the RAM is reading and while the engine is idle. The bus word is steady during any strobe. The memory address moves only in steps of 2. `done` lasts one cycle and leaves the engine idle. Other properties need whole scenarios from the bench. These are the order of strobes within a word and the correct word ending up in each location on either side of the bus. They also include the exact phase widths and job latencies for different `phase_cycles`, the zero-length and no-operation cases, and a `start` pulse that must be ignored in the middle of a job.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [1:0] {
      CMD_NONE     = 2'b00,
      CMD_BUS2MEM  = 2'b01,
      CMD_MEM2RAM  = 2'b10,
      CMD_MEM2DISP = 2'b11
   } pbus_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_SAMPLE,
      ST_FETCH,
      ST_SETUP,
      ST_STRB_LO,
      ST_STRB_HI,
      ST_CNT_LO,
      ST_CNT_HI,
      ST_FINISH
   } pbus_state_e;

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] phase_len,
   output logic          expire
);
   localparam logic [PW-1:0] ONE = PW'(1);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (phase_len == '0) ? ONE : phase_len;
      else if (cnt != '0)
         cnt <= cnt - ONE;
   end

   // last cycle of the current phase
   assign expire = (cnt == ONE);

endmodule

// File: rtl/pbus_word_path.sv
module pbus_word_path #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16,
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          adv,
   input  logic          latch_word,
   input  logic [AW-1:0] base_addr,
   input  logic [CW-1:0] word_count,
   input  logic [PW-1:0] phase_cycles,
   input  logic [DW-1:0] mem_rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          remain_zero,
   output logic [PW-1:0] phase_eff,
   output logic [DW-1:0] bus_dout
);
   localparam logic [AW-1:0] ADDR_STEP = AW'(2);
   localparam logic [CW-1:0] CNT_ONE   = CW'(1);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] remain_q;
   logic [PW-1:0] phase_q;
   logic [DW-1:0] out_latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         remain_q <= '0;
         phase_q  <= '0;
      end else if (accept) begin
         addr_q   <= base_addr;
         remain_q <= word_count;
         phase_q  <= phase_cycles;
      end else if (adv) begin
         addr_q   <= addr_q + ADDR_STEP;
         remain_q <= remain_q - CNT_ONE;
      end
   end

   // the data field of the output latch is replaced whole on each word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_latch <= '0;
      else if (latch_word)
         out_latch <= mem_rd_data;
   end

   assign mem_addr    = addr_q;
   assign remain_zero = (remain_q == '0);
   assign phase_eff   = accept ? phase_cycles : phase_q;
   assign bus_dout    = out_latch;

endmodule

// File: rtl/pbus_seq_fsm.sv
module pbus_seq_fsm
   import pbus_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [1:0]  cmd,
   input  logic        count_zero,
   input  logic        remain_zero,
   input  logic        expire,
   output pbus_state_e state,
   output pbus_cmd_e   job,
   output logic        accept,
   output logic        adv,
   output logic        latch_word,
   output logic        tmr_load
);
   pbus_state_e state_q, nxt;
   pbus_cmd_e   job_q;
   pbus_cmd_e   cmd_in;

   assign cmd_in = pbus_cmd_e'(cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         job_q   <= CMD_NONE;
      end else begin
         state_q <= nxt;
         if (accept)
            job_q <= cmd_in;
      end
   end

   always_comb begin
      nxt        = state_q;
      accept     = 1'b0;
      adv        = 1'b0;
      latch_word = 1'b0;
      tmr_load   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               accept = 1'b1;
               if (count_zero || cmd_in == CMD_NONE)
                  nxt = ST_FINISH;
               else if (cmd_in == CMD_BUS2MEM) begin
                  nxt      = ST_SETTLE;
                  tmr_load = 1'b1;
               end else
                  nxt = ST_FETCH;
            end
         end
         ST_SETTLE: if (expire) nxt = ST_SAMPLE;
         ST_SAMPLE: begin
            adv      = 1'b1;
            nxt      = ST_CNT_LO;
            tmr_load = 1'b1;
         end
         ST_FETCH: nxt = ST_SETUP;
         ST_SETUP: begin
            adv        = 1'b1;
            latch_word = 1'b1;
            nxt        = ST_STRB_LO;
            tmr_load   = 1'b1;
         end
         ST_STRB_LO: begin
            if (expire) begin
               nxt      = ST_STRB_HI;
               tmr_load = 1'b1;
            end
         end
         ST_STRB_HI: begin
            if (expire) begin
               if (job_q == CMD_MEM2DISP)
                  nxt = remain_zero ? ST_FINISH : ST_FETCH;
               else begin
                  nxt      = ST_CNT_LO;
                  tmr_load = 1'b1;
               end
            end
         end
         ST_CNT_LO: begin
            if (expire) begin
               nxt      = ST_CNT_HI;
               tmr_load = 1'b1;
            end
         end
         ST_CNT_HI: begin
            if (expire) begin
               if (remain_zero)
                  nxt = ST_FINISH;
               else if (job_q == CMD_BUS2MEM)
                  nxt = ST_SAMPLE;
               else
                  nxt = ST_FETCH;
            end
         end
         ST_FINISH: nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   assign state = state_q;
   assign job   = job_q;

endmodule

// File: rtl/pbus_xfer_engine.sv
module pbus_xfer_engine
   import pbus_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16,
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    cmd,
   input  logic [AW-1:0] base_addr,
   input  logic [CW-1:0] word_count,
   input  logic [PW-1:0] phase_cycles,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd_en,
   input  logic [DW-1:0] mem_rd_data,
   output logic          mem_wr_en,
   output logic [DW-1:0] mem_wr_data,
   input  logic [DW-1:0] bus_din,
   output logic [DW-1:0] bus_dout,
   output logic          bus_oe,
   output logic          ram_rd_n,
   output logic          ram_wr_n,
   output logic          cnt_clk,
   output logic          disp_cs_n,
   output logic          disp_wr_n
);
   generate
      if (AW < 2)  begin : g_bad_aw $error("AW must allow byte steps of 2"); end
      if (CW < 1)  begin : g_bad_cw $error("CW must be at least 1"); end
      if (DW < 1)  begin : g_bad_dw $error("DW must be at least 1"); end
      if (PW < 1)  begin : g_bad_pw $error("PW must be at least 1"); end
   endgenerate

   pbus_state_e   state;
   pbus_cmd_e     job;
   logic          accept, adv, latch_word, tmr_load, expire, remain_zero;
   logic [PW-1:0] phase_eff;
   logic          in_read, is_write_job, write_active, disp_strobe;

   pbus_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cmd         (cmd),
      .count_zero  (word_count == '0),
      .remain_zero (remain_zero),
      .expire      (expire),
      .state       (state),
      .job         (job),
      .accept      (accept),
      .adv         (adv),
      .latch_word  (latch_word),
      .tmr_load    (tmr_load)
   );

   pbus_phase_timer #(.PW(PW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tmr_load),
      .phase_len (phase_eff),
      .expire    (expire)
   );

   pbus_word_path #(.AW(AW), .CW(CW), .DW(DW), .PW(PW)) u_path (
      .clk          (clk),
      .rst_n        (rst_n),
      .accept       (accept),
      .adv          (adv),
      .latch_word   (latch_word),
      .base_addr    (base_addr),
      .word_count   (word_count),
      .phase_cycles (phase_cycles),
      .mem_rd_data  (mem_rd_data),
      .mem_addr     (mem_addr),
      .remain_zero  (remain_zero),
      .phase_eff    (phase_eff),
      .bus_dout     (bus_dout)
   );

   assign in_read = (job == CMD_BUS2MEM) &&
                    (state inside {ST_SETTLE, ST_SAMPLE, ST_CNT_LO, ST_CNT_HI});
   assign is_write_job = (job == CMD_MEM2RAM) || (job == CMD_MEM2DISP);
   assign write_active = is_write_job &&
                         (state inside {ST_FETCH, ST_SETUP, ST_STRB_LO,
                                        ST_STRB_HI, ST_CNT_LO, ST_CNT_HI});
   assign disp_strobe  = (job == CMD_MEM2DISP) && (state == ST_STRB_LO);

   assign busy        = (state != ST_IDLE);
   assign done        = (state == ST_FINISH);
   assign mem_rd_en   = (state == ST_FETCH);
   assign mem_wr_en   = (state == ST_SAMPLE);
   assign mem_wr_data = bus_din;
   assign bus_oe      = write_active;
   assign ram_rd_n    = !in_read;
   assign ram_wr_n    = !((job == CMD_MEM2RAM) && (state == ST_STRB_LO));
   assign cnt_clk     = !(state == ST_CNT_LO);
   assign disp_cs_n   = !disp_strobe;
   assign disp_wr_n   = !disp_strobe;

endmodule

// File: rtl/pbus_xfer_checker.sv
module pbus_xfer_checker #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] bus_dout,
   input logic          bus_oe,
   input logic          ram_rd_n,
   input logic          ram_wr_n,
   input logic          cnt_clk,
   input logic          disp_cs_n,
   input logic          disp_wr_n
);
   // R1 / R8: an idle engine drives nothing and strobes nothing
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ram_rd_n && ram_wr_n && cnt_clk && disp_cs_n && disp_wr_n && !bus_oe));

   // R8: drivers stay off while the RAM is reading
   a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_rd_n |-> !bus_oe);

   // R2 / R4: only one strobe kind low at a time
   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!ram_wr_n, !disp_wr_n, !cnt_clk}) <= 1);

   // R2: word steady across a RAM write strobe
   a_r2_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_wr_n && $past(!ram_wr_n)) |-> $stable(bus_dout));

   // R4: word steady across a display strobe, and driven while strobing
   a_r4_disp_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_cs_n && $past(!disp_cs_n)) |-> ($stable(bus_dout) && bus_oe));

   // R5: within a job the address only ever moves up by 2
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mem_addr)) |-> (mem_addr == $past(mem_addr) + AW'(2)));

   // R9: done lasts one cycle and leaves the engine idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R3: read enable released when a job ends
   a_r3_rd_released: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ram_rd_n);
endmodule

bind pbus_xfer_engine pbus_xfer_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .mem_addr  (mem_addr),
   .bus_dout  (bus_dout),
   .bus_oe    (bus_oe),
   .ram_rd_n  (ram_rd_n),
   .ram_wr_n  (ram_wr_n),
   .cnt_clk   (cnt_clk),
   .disp_cs_n (disp_cs_n),
   .disp_wr_n (disp_wr_n)
);

// File: tb/pbus_xfer_engine_test.sv
module pbus_xfer_engine_test;
   localparam int AW = 16, CW = 16, DW = 16, PW = 8;

   logic          clk = 0, rst_n = 0;
   logic          start = 0;
   logic [1:0]    cmd = 0;
   logic [AW-1:0] base_addr = 0;
   logic [CW-1:0] word_count = 0;
   logic [PW-1:0] phase_cycles = 0;
   logic          busy, done, mem_rd_en, mem_wr_en, bus_oe;
   logic          ram_rd_n, ram_wr_n, cnt_clk, disp_cs_n, disp_wr_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rd_data = 0, mem_wr_data, bus_din, bus_dout;

   always #5 clk = ~clk;

   pbus_xfer_engine #(.AW(AW), .CW(CW), .DW(DW), .PW(PW)) uut (.*);

   int n_checks = 0, n_fail = 0;

   // bench memories
   logic [15:0] wmem [0:255];
   logic [15:0] sram [0:255];
   logic [15:0] disp_log [0:63];
   logic [AW-1:0] rd_log [0:63];
   logic [7:0]  ptr = 0;

   assign bus_din = sram[ptr];

   // job observation counters
   int wr_falls, cnt_falls, disp_falls, rd_reqs, disp_rises;
   int low_min, low_max, run_wr, run_cnt, run_disp;
   int oe_in_read, cs_wr_split, rd_low_seen, cnt_in_disp;
   logic p_wr = 1, p_cnt = 1, p_disp = 1;

   logic          q_rd, q_wr;
   logic [7:0]    q_idx;
   logic [15:0]   q_data;

   task automatic clear_obs();
      wr_falls = 0; cnt_falls = 0; disp_falls = 0; rd_reqs = 0; disp_rises = 0;
      low_min = 9999; low_max = 0; run_wr = 0; run_cnt = 0; run_disp = 0;
      oe_in_read = 0; cs_wr_split = 0; rd_low_seen = 0; cnt_in_disp = 0;
   endtask

   task automatic note_run(input int r);
      if (r < low_min) low_min = r;
      if (r > low_max) low_max = r;
   endtask

   always @(negedge clk) begin
      q_rd   = mem_rd_en;
      q_wr   = mem_wr_en;
      q_idx  = mem_addr[8:1];
      q_data = mem_wr_data;
      if (rst_n) begin
         if (mem_rd_en) begin
            if (rd_reqs < 64) rd_log[rd_reqs] = mem_addr;
            rd_reqs++;
         end
         if (!ram_wr_n) run_wr++;
         if (!cnt_clk) run_cnt++;
         if (!disp_wr_n) run_disp++;
         if (p_wr && !ram_wr_n) wr_falls++;
         if (!p_wr && ram_wr_n) begin sram[ptr] = bus_dout; note_run(run_wr); run_wr = 0; end
         if (p_cnt && !cnt_clk) begin
            cnt_falls++;
            if (uut.job == pbus_pkg::CMD_MEM2DISP) cnt_in_disp++;
         end
         if (!p_cnt && cnt_clk) begin ptr = ptr + 8'd1; note_run(run_cnt); run_cnt = 0; end
         if (p_disp && !disp_wr_n) disp_falls++;
         if (!p_disp && disp_wr_n) begin
            if (disp_rises < 64) disp_log[disp_rises] = bus_dout;
            disp_rises++;
            note_run(run_disp); run_disp = 0;
         end
         if (!ram_rd_n) rd_low_seen++;
         if (!ram_rd_n && bus_oe) oe_in_read++;
         if (disp_cs_n != disp_wr_n) cs_wr_split++;
         p_wr = ram_wr_n; p_cnt = cnt_clk; p_disp = disp_wr_n;
      end
   end

   always @(posedge clk) begin
      if (q_rd) mem_rd_data <= wmem[q_idx];
      if (q_wr) wmem[q_idx] <= q_data;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int qof(input int p);
      return (p == 0) ? 1 : p;
   endfunction

   // launches a job; returns cycles from start to done
   task automatic run_job(input logic [1:0] c, input int base, input int n,
                          input int p, output int lat);
      clear_obs();
      ptr = 0;
      @(negedge clk);
      start = 1; cmd = c; base_addr = AW'(base); word_count = CW'(n); phase_cycles = PW'(p);
      @(negedge clk);
      start = 0;
      lat = 1;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
      end
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "bus_oe", bus_oe, 0);
      chk("R1", "strobes", {ram_rd_n, ram_wr_n, cnt_clk, disp_cs_n, disp_wr_n}, 5'b11111);
   endtask

   task automatic t_mem_to_ram(input int base, input int n, input int p);
      int lat;
      for (int i = 0; i < n; i++) wmem[base/2 + i] = 16'hA000 + 16'(i * 37 + p);
      for (int i = 0; i < 64; i++) sram[i] = 16'h0;
      run_job(2'b10, base, n, p, lat);
      chk("R9", "m2r latency", lat, n * (2 + 4 * qof(p)) + 1);
      chk("R2", "write strobes", wr_falls, n);
      chk("R2", "counter pulses", cnt_falls, n);
      for (int i = 0; i < n; i++)
         chk("R2", "ram word", sram[i], wmem[base/2 + i]);
      for (int i = 0; i < n; i++)
         chk("R5", "read address", rd_log[i], 32'(base + 2 * i));
      chk("R6", "min low phase", low_min, qof(p));
      chk("R6", "max low phase", low_max, qof(p));
      chk("R8", "oe after job", bus_oe, 0);
      chk("R9", "idle after done", {busy, done}, 2'b00);
   endtask

   task automatic t_ram_to_mem(input int base, input int n, input int p);
      int lat;
      for (int i = 0; i < 64; i++) sram[i] = 16'h5000 + 16'(i * 11 + p);
      for (int i = 0; i <= n; i++) wmem[base/2 + i] = 16'hDEAD;
      run_job(2'b01, base, n, p, lat);
      chk("R9", "b2m latency", lat, qof(p) + n * (1 + 2 * qof(p)) + 1);
      for (int i = 0; i < n; i++)
         chk("R3", "stored word", wmem[base/2 + i], 16'h5000 + 16'(i * 11 + p));
      chk("R5", "word past end untouched", wmem[base/2 + n], 16'hDEAD);
      chk("R3", "counter pulses", cnt_falls, n);
      chk("R3", "rd low cycles", rd_low_seen, lat - 1);
      chk("R3", "rd released", ram_rd_n, 1);
      chk("R8", "oe during read", oe_in_read, 0);
      chk("R3", "no write strobe", wr_falls, 0);
      chk("R6", "counter low phase", low_max, qof(p));
   endtask

   task automatic t_to_display(input int base, input int n, input int p);
      int lat;
      for (int i = 0; i < n; i++) wmem[base/2 + i] = 16'hC300 ^ 16'(i * 513);
      run_job(2'b11, base, n, p, lat);
      chk("R9", "disp latency", lat, n * (2 + 2 * qof(p)) + 1);
      chk("R4", "display strobes", disp_falls, n);
      chk("R4", "cs and wr together", cs_wr_split, 0);
      chk("R4", "no counter pulse", cnt_falls + cnt_in_disp, 0);
      chk("R4", "cs high at end", disp_cs_n, 1);
      for (int i = 0; i < n; i++)
         chk("R4", "display word", disp_log[i], wmem[base/2 + i]);
      chk("R6", "display low phase", low_max, qof(p));
   endtask

   task automatic t_zero_len();
      int lat;
      run_job(2'b10, 8, 0, 3, lat);
      chk("R7", "zero latency", lat, 1);
      chk("R7", "zero strobes", wr_falls + cnt_falls + disp_falls, 0);
      chk("R7", "zero mem reads", rd_reqs, 0);
   endtask

   task automatic t_no_cmd();
      int lat;
      run_job(2'b00, 8, 4, 2, lat);
      chk("R11", "none latency", lat, 1);
      chk("R11", "none strobes", wr_falls + cnt_falls + disp_falls + rd_low_seen, 0);
   endtask

   task automatic t_busy_restart();
      int lat;
      for (int i = 0; i < 3; i++) wmem[100 + i] = 16'h7700 + 16'(i);
      clear_obs();
      ptr = 0;
      @(negedge clk);
      start = 1; cmd = 2'b10; base_addr = 16'd200; word_count = 16'd3; phase_cycles = 8'd1;
      @(negedge clk);
      start = 0;
      repeat (4) @(negedge clk);
      start = 1; cmd = 2'b01; base_addr = 16'd40; word_count = 16'd5;
      @(negedge clk);
      start = 0;
      lat = 6;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
      end
      chk("R10", "latency unchanged", lat, 3 * (2 + 4) + 1);
      chk("R10", "write strobes", wr_falls, 3);
      chk("R10", "no read phase", rd_low_seen, 0);
      repeat (3) @(negedge clk);
      chk("R10", "no second job", busy, 0);
      chk("R10", "last word", sram[2], 16'h7702);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      clear_obs();
      for (int i = 0; i < 256; i++) begin wmem[i] = 16'h0; sram[i] = 16'h0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset_state();
      t_mem_to_ram(16, 4, 1);
      t_mem_to_ram(64, 3, 3);
      t_mem_to_ram(130, 2, 0);
      t_ram_to_mem(20, 5, 1);
      t_ram_to_mem(200, 3, 2);
      t_to_display(40, 4, 1);
      t_to_display(90, 2, 4);
      t_zero_len();
      t_no_cmd();
      t_busy_restart();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule